// File: doc/BRIEF.md
# Acknowledge Check and Error Frame Sequencer

This block sits on the transmit side of a differential two-wire field bus controller. When the frame serializer reaches the acknowledge slot of the node's own frame, it hands control to this sequencer. The sequencer keeps its output recessive through the slot and reads the bus. A dominant reading means some receiver accepted the frame. A recessive reading means nobody did, so after the delimiter the sequencer drives an error frame and asks for a retransmission.

The same error frame can be started by an outside error request, for example a stuff violation found by the receiver. The error flag takes its polarity from the node's error state. An error-active node writes six dominant bits that break the frame for every other node. An error-passive node writes six recessive bits that disturb nobody. Eight recessive delimiter bits and three recessive interframe bits then follow. Every step advances on a one-cycle bit tick from the bit timing logic. On the bus, logic 0 is dominant and logic 1 is recessive.

Top module: `ackerr_seq`

## Requirements
- R1: After reset, and at any time the sequencer is idle, tx_bit is 1 (recessive) and busy is 0.
- R2: State changes only on a clock cycle where bit_tick is 1. err_req, ack_start, bus_rx and err_passive are only looked at in such a cycle.
- R3: A tick with ack_start in idle opens the acknowledge slot. The slot bit and the delimiter bit that follows are both sent as 1, and busy is 1 during both. bus_rx is sampled on the tick that closes the slot.
- R4: If the slot sample was 0 (dominant), the tick that closes the delimiter returns the sequencer to idle. In the following cycle done and ack_ok are each 1 for one cycle and retx_req stays 0. No error frame is sent.
- R5: If the slot sample was 1 (recessive), the tick that closes the delimiter starts an error frame. In the cycle after that frame ends, done and retx_req are each 1 for one cycle.
- R6: In error-active state (err_passive 0), the error frame is 6 bits of 0, then 8 delimiter bits of 1, then 3 interframe bits of 1, for 17 bit times in all. busy is 1 throughout.
- R7: In error-passive state (err_passive 1), the 6 flag bits are 1 instead of 0. The delimiter and interframe parts are unchanged, and busy is 1 for all 17 bits.
- R8: A tick with err_req in idle starts an error frame at the next bit, and err_req wins over ack_start on the same tick. At the end, done is pulsed and retx_req stays 0.
- R9: A tick with err_req during the acknowledge slot or its delimiter drops the acknowledge check and starts an error frame with no retransmit request.
- R10: err_req while an error frame is already running is ignored: the frame keeps its 17-bit length and its retransmit outcome.
- R11: The flag polarity is taken from err_passive on the tick that starts the frame. Later changes of err_passive do not affect the flag bits.
- R12: done is never 1 in two consecutive cycles. retx_req and ack_ok are only ever 1 together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse marking a bit boundary |
| ack_start | input | 1 | Own frame has reached its acknowledge slot |
| err_req | input | 1 | External request to send an error frame |
| err_passive | input | 1 | 1 = node is error-passive, 0 = error-active |
| bus_rx | input | 1 | Bus level read back (0 dominant, 1 recessive) |
| tx_bit | output | 1 | Bus level to drive (0 dominant, 1 recessive) |
| busy | output | 1 | Sequencer is not idle |
| done | output | 1 | One-cycle pulse when a sequence finishes |
| retx_req | output | 1 | One-cycle pulse with done after an unacknowledged frame |
| ack_ok | output | 1 | One-cycle pulse with done after an acknowledged frame |

## Verification
The bench counts every flag, delimiter and interframe bit one by one. A design with an off-by-one segment length would end the frame early or late and raise done on the wrong tick. It flips err_passive and raises err_req in the middle of a running frame. A design that did not latch the polarity would flip the flag bits, and one that honoured the late request would restart or lengthen the frame. It also checks err_req against ack_start on the same tick, and err_req inside the acknowledge slot. A wrong priority would open a slot instead of flagging, or would ask for a retransmission the bus never refused. Finally, it holds requests without a bit tick, which would catch a design that advances on the clock alone.

// File: rtl/ackerr_pkg.sv
package ackerr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK_SLOT,
        ST_ACK_DELIM,
        ST_ERR_FLAG,
        ST_ERR_DELIM,
        ST_INTERFRAME
    } seq_state_e;

    typedef enum logic {
        CAUSE_REQ,
        CAUSE_NOACK
    } err_cause_e;

    typedef struct packed {
        logic done;
        logic retx;
        logic ack_ok;
    } seq_report_t;

    localparam logic BUS_DOM = 1'b0;
    localparam logic BUS_REC = 1'b1;

    function automatic logic flag_level(input logic passive);
        return passive ? BUS_REC : BUS_DOM;
    endfunction

    function automatic logic is_counted(input seq_state_e st);
        return (st == ST_ERR_FLAG) || (st == ST_ERR_DELIM) || (st == ST_INTERFRAME);
    endfunction

endpackage

// File: rtl/ackerr_bitcount.sv
module ackerr_bitcount #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == limit - 1'b1);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt < limit)); // R6

endmodule

// File: rtl/ackerr_linedrv.sv
module ackerr_linedrv
    import ackerr_pkg::*;
(
    input  seq_state_e state,
    input  logic       flag_passive,
    output logic       tx_bit
);
    always_comb begin
        if (state == ST_ERR_FLAG) begin
            tx_bit = flag_level(flag_passive);
        end else begin
            tx_bit = BUS_REC;
        end
    end
endmodule

// File: rtl/ackerr_seq.sv
module ackerr_seq
    import ackerr_pkg::*;
#(
    parameter int FLAG_BITS  = 6,
    parameter int DELIM_BITS = 8,
    parameter int IFS_BITS   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic ack_start,
    input  logic err_req,
    input  logic err_passive,
    input  logic bus_rx,
    output logic tx_bit,
    output logic busy,
    output logic done,
    output logic retx_req,
    output logic ack_ok
);
    localparam int MAX_A   = (FLAG_BITS > DELIM_BITS) ? FLAG_BITS : DELIM_BITS;
    localparam int MAX_SEG = (MAX_A > IFS_BITS) ? MAX_A : IFS_BITS;
    localparam int CW      = $clog2(MAX_SEG + 1);

    seq_state_e  state, state_nxt;
    err_cause_e  cause;
    logic        flag_passive;
    logic        ack_seen;
    seq_report_t report;
    logic [CW-1:0] seg_limit;
    logic        seg_last;
    logic        cnt_restart;
    logic        cnt_step;
    logic        start_err;

    always_comb begin
        case (state)
            ST_ERR_FLAG:   seg_limit = CW'(FLAG_BITS);
            ST_ERR_DELIM:  seg_limit = CW'(DELIM_BITS);
            ST_INTERFRAME: seg_limit = CW'(IFS_BITS);
            default:       seg_limit = CW'(1);
        endcase
    end

    always_comb begin
        state_nxt = state;
        if (bit_tick) begin
            case (state)
                ST_IDLE: begin
                    if (err_req)        state_nxt = ST_ERR_FLAG;
                    else if (ack_start) state_nxt = ST_ACK_SLOT;
                end
                ST_ACK_SLOT: begin
                    state_nxt = err_req ? ST_ERR_FLAG : ST_ACK_DELIM;
                end
                ST_ACK_DELIM: begin
                    if (err_req || !ack_seen) state_nxt = ST_ERR_FLAG;
                    else                      state_nxt = ST_IDLE;
                end
                ST_ERR_FLAG:   if (seg_last) state_nxt = ST_ERR_DELIM;
                ST_ERR_DELIM:  if (seg_last) state_nxt = ST_INTERFRAME;
                ST_INTERFRAME: if (seg_last) state_nxt = ST_IDLE;
                default:       state_nxt = ST_IDLE;
            endcase
        end
    end

    assign start_err   = (state_nxt == ST_ERR_FLAG) && !is_counted(state);
    assign cnt_restart = bit_tick && (state_nxt != state);
    assign cnt_step    = bit_tick && is_counted(state);

    ackerr_bitcount #(.CW(CW)) u_count (
        .clk     (clk),
        .rst     (rst),
        .restart (cnt_restart),
        .step    (cnt_step),
        .limit   (seg_limit),
        .last    (seg_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            cause        <= CAUSE_REQ;
            flag_passive <= 1'b0;
            ack_seen     <= 1'b0;
            report       <= '0;
        end else begin
            state  <= state_nxt;
            report <= '0;
            if (bit_tick && state == ST_ACK_SLOT) begin
                ack_seen <= (bus_rx == BUS_DOM);
            end
            if (start_err) begin
                flag_passive <= err_passive;
                cause <= (state == ST_ACK_DELIM && !err_req) ? CAUSE_NOACK : CAUSE_REQ;
            end
            if (bit_tick && state == ST_ACK_DELIM && state_nxt == ST_IDLE) begin
                report.done   <= 1'b1;
                report.ack_ok <= 1'b1;
            end
            if (bit_tick && state == ST_INTERFRAME && state_nxt == ST_IDLE) begin
                report.done <= 1'b1;
                report.retx <= (cause == CAUSE_NOACK);
            end
        end
    end

    ackerr_linedrv u_drv (
        .state        (state),
        .flag_passive (flag_passive),
        .tx_bit       (tx_bit)
    );

    assign busy     = (state != ST_IDLE);
    assign done     = report.done;
    assign retx_req = report.retx;
    assign ack_ok   = report.ack_ok;

    AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_bit); // R1
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(state)); // R2
    AST_ACTIVE_FLAG_DOM: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERR_FLAG && !flag_passive) |-> !tx_bit); // R6
    AST_PASSIVE_FLAG_REC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERR_FLAG && flag_passive) |-> tx_bit); // R7
    AST_FLAG_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERR_FLAG && $past(state) == ST_ERR_FLAG) |-> $stable(flag_passive)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12
    AST_RETX_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        retx_req |-> done); // R12
    AST_ACKOK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        ack_ok |-> (done && !retx_req)); // R4

endmodule

// File: tb/ackerr_seq_test.sv
module ackerr_seq_test;

    typedef struct {
        logic  tx;
        logic  busy;
        logic  done;
        logic  retx;
        logic  ok;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b0;
    logic ack_start = 1'b0;
    logic err_req = 1'b0;
    logic err_passive = 1'b0;
    logic bus_rx = 1'b1;
    logic tx_bit, busy, done, retx_req, ack_ok;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    exp_t q[$];
    exp_t it;

    always #4 clk = ~clk;

    ackerr_seq uut (
        .clk         (clk),
        .rst         (rst),
        .bit_tick    (bit_tick),
        .ack_start   (ack_start),
        .err_req     (err_req),
        .err_passive (err_passive),
        .bus_rx      (bus_rx),
        .tx_bit      (tx_bit),
        .busy        (busy),
        .done        (done),
        .retx_req    (retx_req),
        .ack_ok      (ack_ok)
    );

    // Monitor: pops one expected item for every bit tick and compares
    always @(posedge clk) begin
        if (!rst && bit_tick) begin
            #2;
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL %s: tick with empty scoreboard", "R2");
            end else begin
                it = q.pop_front();
                if (tx_bit !== it.tx || busy !== it.busy || done !== it.done ||
                    retx_req !== it.retx || ack_ok !== it.ok) begin
                    fails++;
                    $display("FAIL %s: tx/busy/done/retx/ok actual %b%b%b%b%b expected %b%b%b%b%b",
                             it.tag, tx_bit, busy, done, retx_req, ack_ok,
                             it.tx, it.busy, it.done, it.retx, it.ok);
                end
            end
        end
    end

    task automatic check_now(input logic x_tx, input logic x_busy, input string tag);
        checks++;
        if (tx_bit !== x_tx || busy !== x_busy || done !== 1'b0) begin
            fails++;
            $display("FAIL %s: tx/busy/done actual %b%b%b expected %b%b0",
                     tag, tx_bit, busy, done, x_tx, x_busy);
        end
    endtask

    // Driver: applies one bit tick and pushes the expected outcome
    task automatic send_bit(input logic e_in, input logic a_in, input logic b_in, input logic p_in,
                            input logic x_tx, input logic x_busy, input logic x_done,
                            input logic x_retx, input logic x_ok, input string tag);
        exp_t e;
        @(negedge clk);
        err_req = e_in; ack_start = a_in; bus_rx = b_in; err_passive = p_in;
        e.tx = x_tx; e.busy = x_busy; e.done = x_done; e.retx = x_retx; e.ok = x_ok; e.tag = tag;
        q.push_back(e);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0; err_req = 1'b0; ack_start = 1'b0; bus_rx = 1'b1;
        @(negedge clk);
    endtask

    // Remaining 16 bits of an error frame after the first flag bit
    task automatic err_tail(input logic lvl, input logic x_retx, input logic e_in,
                            input logic p_in, input string tag);
        for (int i = 0; i < 5; i++)
            send_bit(e_in, 1'b0, 1'b1, p_in, lvl, 1'b1, 1'b0, 1'b0, 1'b0, tag);
        for (int i = 0; i < 11; i++)
            send_bit(e_in, 1'b0, 1'b1, p_in, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, tag);
        send_bit(e_in, 1'b0, 1'b1, p_in, 1'b1, 1'b0, 1'b1, x_retx, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_now(1'b1, 1'b0, "R1");

        // R2: requests held without a tick change nothing
        ack_start = 1'b1; err_req = 1'b1;
        repeat (5) @(negedge clk);
        check_now(1'b1, 1'b0, "R2");
        ack_start = 1'b0; err_req = 1'b0;

        // R3/R4: acknowledged frame
        send_bit(0, 1, 1, 0, 1, 1, 0, 0, 0, "R3");
        send_bit(0, 0, 0, 0, 1, 1, 0, 0, 0, "R3");
        send_bit(0, 0, 1, 0, 1, 0, 1, 0, 1, "R4");
        check_now(1'b1, 1'b0, "R12");

        // R5/R6: missing acknowledge, active flag
        send_bit(0, 1, 1, 0, 1, 1, 0, 0, 0, "R3");
        send_bit(0, 0, 1, 0, 1, 1, 0, 0, 0, "R5");
        send_bit(0, 0, 1, 0, 0, 1, 0, 0, 0, "R5");
        err_tail(1'b0, 1'b1, 1'b0, 1'b0, "R6");

        // R8/R7: external request beats ack_start, passive flag
        send_bit(1, 1, 1, 1, 1, 1, 0, 0, 0, "R8");
        err_tail(1'b1, 1'b0, 1'b0, 1'b1, "R7");

        // R9: request inside the acknowledge slot
        send_bit(0, 1, 1, 0, 1, 1, 0, 0, 0, "R3");
        send_bit(1, 0, 1, 0, 0, 1, 0, 0, 0, "R9");
        err_tail(1'b0, 1'b0, 1'b0, 0, "R9");

        // R10/R11: requests and a passive change during a running frame
        send_bit(1, 0, 1, 0, 0, 1, 0, 0, 0, "R8");
        err_tail(1'b0, 1'b0, 1'b1, 1'b1, "R10");

        // R5/R7: missing acknowledge while passive
        send_bit(0, 1, 1, 1, 1, 1, 0, 0, 0, "R3");
        send_bit(0, 0, 1, 1, 1, 1, 0, 0, 0, "R5");
        send_bit(0, 0, 1, 1, 1, 1, 0, 0, 0, "R7");
        err_tail(1'b1, 1'b1, 1'b0, 1'b0, "R11");

        repeat (3) @(negedge clk);
        check_now(1'b1, 1'b0, "R1");
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d expected items left, expected 0", q.size());
        end
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule